// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte Lanes

This block is a single-port, clocked static memory that sits behind a processor cache. It stores 32 data bits and 4 parity bits per word, split into four byte lanes with one parity bit per lane. An access opens when one of two active-low address strobes is sampled low: the processor-side strobe or the controller-side strobe. The start address is captured, and up to three further words of a 4-word group follow when the advance input is pulled low. A static strap picks the visiting order. Reads are registered, so data shows up one clock after the edge that presented its address. The shared data bus is split into separate write-data inputs, read-data outputs and a drive-enable output.

Output driving is managed by a phase machine with five states. `PH_DESEL` is entered at reset and on any edge with the chip deselected (`ce_n` high). `PH_SLEEP` is forced asynchronously while `sleep_i` is high. When `ce_n` is low on an edge, both of those states move to `PH_FIRST`, the quiet first cycle after deselect. `PH_FIRST`, `PH_READ` and `PH_WRITE` move to `PH_WRITE` after an edge that performed a write, to `PH_READ` after an edge that performed a read, and to `PH_DESEL` when `ce_n` is high. The bus is driven only in `PH_READ`.

Each selected edge performs one access, at an effective address computed as follows:
- A strobe edge uses the new address.
- An advance edge uses the next burst position.
- An edge with neither uses the held position.

The processor-side strobe always reads. Any other selected edge writes when the byte-write enable is low, and reads otherwise.

Top module: `burst_sram`

## Requirements
- R1: On an edge with `ce_n` low, `sleep_i` low, `ctl_strb_n` low and `bwe_n` high, the word at `addr_i` is read. Half a cycle later `{rpar, rdata}` holds that word, and `dq_oe` is high if the edge was not the first selected edge after deselect and `oe_n` is low.
- R2: When both strobes are low on the same edge, the access is a read of `addr_i`, whatever `bwe_n` and `lane_we_n` are. Memory is left unchanged.
- R3: With `burst_mode` low, advance edges (`adv_n` low, both strobes high) visit offsets s+1, s+2, s+3, s (mod 4) within the 4-word group, where s = `addr_i[1:0]` at the strobe edge.
- R4: With `burst_mode` high, the k-th advance edge after the strobe uses offset s XOR k, for k = 1..3.
- R5: When `bwe_n` is high, `lane_we_n` has no effect. A controller-strobe edge then reads the addressed word.
- R6: On a write, lane i (`wdata[8i+7:8i]` together with `wpar[i]`) is stored only when `lane_we_n[i]` is low. The other lanes keep their contents.
- R7: `dq_oe` is high only while `oe_n` is low, and it follows `oe_n` without waiting for a clock.
- R8: After an edge that performs a write, `dq_oe` is low for that cycle.
- R9: After the first selected edge that follows a deselected or sleeping edge, `dq_oe` is low even if a read was done. The read data is still loaded.
- R10: An edge with `ce_n` high performs no access. It leaves the address and burst position held, and it leaves `rdata` unchanged. `dq_oe` is then low.
- R11: While `sleep_i` is high, `dq_oe` is low at once, no write or read takes place, and memory contents are kept.
- R12: A selected edge with both strobes and `adv_n` high repeats the access at the current burst position.
- R13: During reset `dq_oe` is low. After reset `rdata` and `rpar` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Asynchronous sleep request, active high |
| ce_n | input | 1 | Chip select, active low |
| cpu_strb_n | input | 1 | Processor-side address strobe, active low, higher priority |
| ctl_strb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| addr_i | input | 8 | Word address (clog2 of DEPTH) |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_we_n | input | 4 | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low |
| burst_mode | input | 1 | Static strap: 0 linear, 1 interleaved |
| wdata | input | 32 | Write data, four byte lanes |
| wpar | input | 4 | Write parity, one bit per lane |
| rdata | output | 32 | Registered read data |
| rpar | output | 4 | Registered read parity |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The hardest case to reach is the quiet first cycle after leaving deselect while the address state is frozen. The deselected edge must carry a strobe and write data that have to be ignored, and then a plain hold edge must re-read the word latched before the deselect. The stimulus chains a strobe read, a deselected write attempt and a hold edge in a row, which shows the R9 drive suppression and the held R10 address in the same window. Sleep is raised between clock edges so that the drive enable is seen dropping before any edge samples it.

// File: rtl/bsram_pkg.sv
`timescale 1ns/1ps
package bsram_pkg;

    localparam int BURST_W = 2;

    // output phase of the current cycle
    typedef enum logic [2:0] {
        PH_DESEL,
        PH_SLEEP,
        PH_FIRST,
        PH_READ,
        PH_WRITE
    } phase_e;

    // access performed on an edge
    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_READ,
        ACC_WRITE
    } acc_e;

    function automatic logic [BURST_W-1:0] burst_off(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] seq,
        input logic               interleave
    );
        return interleave ? (start ^ seq) : (start + seq);
    endfunction

endpackage

// File: rtl/bsram_seq_fsm.sv
`timescale 1ns/1ps
module bsram_seq_fsm
    import bsram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    input  logic ce_n,
    input  logic cpu_strb_n,
    input  logic ctl_strb_n,
    input  logic adv_n,
    input  logic bwe_n,
    output logic load_o,
    output logic step_o,
    output acc_e acc_o,
    output logic drive_ok_o
);

    phase_e ph_q;
    phase_e ph_d;
    logic   active;

    // command decode
    always_comb begin
        active = !ce_n && !sleep_i;
        load_o = active && (!cpu_strb_n || !ctl_strb_n);
        step_o = active && cpu_strb_n && ctl_strb_n && !adv_n;
        if (!active) begin
            acc_o = ACC_NONE;
        end else if (!cpu_strb_n) begin
            acc_o = ACC_READ;           // processor strobe wins, always a read
        end else if (!bwe_n) begin
            acc_o = ACC_WRITE;
        end else begin
            acc_o = ACC_READ;
        end
    end

    // next phase
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_DESEL, PH_SLEEP: begin
                ph_d = ce_n ? PH_DESEL : PH_FIRST;
            end
            PH_FIRST, PH_READ, PH_WRITE: begin
                if (ce_n) begin
                    ph_d = PH_DESEL;
                end else if (acc_o == ACC_WRITE) begin
                    ph_d = PH_WRITE;
                end else begin
                    ph_d = PH_READ;
                end
            end
            default: ph_d = PH_DESEL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n or posedge sleep_i) begin
        if (!rst_n) begin
            ph_q <= PH_DESEL;
        end else if (sleep_i) begin
            ph_q <= PH_SLEEP;
        end else begin
            ph_q <= ph_d;
        end
    end

    // outputs
    always_comb begin
        drive_ok_o = (ph_q == PH_READ);
    end

endmodule

// File: rtl/bsram_addr_ctrl.sv
`timescale 1ns/1ps
module bsram_addr_ctrl
    import bsram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    input  logic          mode_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] eff_addr_o
);

    localparam int HI_W = AW - BURST_W;

    logic [HI_W-1:0]    hi_q, hi_d;
    logic [BURST_W-1:0] start_q, start_d;
    logic [BURST_W-1:0] seq_q, seq_d;

    always_comb begin
        hi_d    = hi_q;
        start_d = start_q;
        seq_d   = seq_q;
        if (load_i) begin
            hi_d    = addr_i[AW-1:BURST_W];
            start_d = addr_i[BURST_W-1:0];
            seq_d   = '0;
        end else if (step_i) begin
            seq_d   = seq_q + 1'b1;
        end
        eff_addr_o = {hi_d, burst_off(start_d, seq_d, mode_i)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q    <= '0;
            start_q <= '0;
            seq_q   <= '0;
        end else begin
            hi_q    <= hi_d;
            start_q <= start_d;
            seq_q   <= seq_d;
        end
    end

endmodule

// File: rtl/bsram_lane_array.sv
`timescale 1ns/1ps
module bsram_lane_array #(
    parameter int DEPTH  = 256,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr_i,
    input  logic             rd_en_i,
    input  logic             wr_en_i,
    input  logic [LANES-1:0] lane_en_n_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [LANES-1:0] wpar_i,
    output logic [DW-1:0]    rdata_o,
    output logic [LANES-1:0] rpar_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W:0] cells [DEPTH];
        logic [LANE_W:0] rd_q;

        always_ff @(posedge clk) begin
            if (wr_en_i && !lane_en_n_i[g]) begin
                cells[addr_i] <= {wpar_i[g], wdata_i[g*LANE_W +: LANE_W]};
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rd_q <= '0;
            end else if (rd_en_i) begin
                rd_q <= cells[addr_i];
            end
        end

        assign rdata_o[g*LANE_W +: LANE_W] = rd_q[LANE_W-1:0];
        assign rpar_o[g]                   = rd_q[LANE_W];
    end

endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram
    import bsram_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_i,
    input  logic             ce_n,
    input  logic             cpu_strb_n,
    input  logic             ctl_strb_n,
    input  logic             adv_n,
    input  logic [AW-1:0]    addr_i,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_we_n,
    input  logic             oe_n,
    input  logic             burst_mode,
    input  logic [DW-1:0]    wdata,
    input  logic [LANES-1:0] wpar,
    output logic [DW-1:0]    rdata,
    output logic [LANES-1:0] rpar,
    output logic             dq_oe
);

    logic          load;
    logic          step;
    acc_e          acc;
    logic          drive_ok;
    logic [AW-1:0] eff_addr;

    bsram_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_i    (sleep_i),
        .ce_n       (ce_n),
        .cpu_strb_n (cpu_strb_n),
        .ctl_strb_n (ctl_strb_n),
        .adv_n      (adv_n),
        .bwe_n      (bwe_n),
        .load_o     (load),
        .step_o     (step),
        .acc_o      (acc),
        .drive_ok_o (drive_ok)
    );

    bsram_addr_ctrl #(.AW(AW)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .step_i     (step),
        .mode_i     (burst_mode),
        .addr_i     (addr_i),
        .eff_addr_o (eff_addr)
    );

    bsram_lane_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (eff_addr),
        .rd_en_i     (acc == ACC_READ),
        .wr_en_i     (acc == ACC_WRITE),
        .lane_en_n_i (lane_we_n),
        .wdata_i     (wdata),
        .wpar_i      (wpar),
        .rdata_o     (rdata),
        .rpar_o      (rpar)
    );

    assign dq_oe = drive_ok && !oe_n && !sleep_i;

endmodule

// File: rtl/bsram_chk.sv
`timescale 1ns/1ps
module bsram_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep_i,
    input logic ce_n,
    input logic cpu_strb_n,
    input logic bwe_n,
    input logic oe_n,
    input logic dq_oe
);

    // R7
    drive_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !oe_n);

    // R8
    write_phase_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !sleep_i && cpu_strb_n && !bwe_n) |=> !dq_oe);

    // R10
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !dq_oe);

    // R9
    wake_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && $past(ce_n)) |=> !dq_oe);

    // R11
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |-> !dq_oe);

    // R13
    always @(negedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!dq_oe);
        end
    end

endmodule

bind burst_sram bsram_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_i    (sleep_i),
    .ce_n       (ce_n),
    .cpu_strb_n (cpu_strb_n),
    .bwe_n      (bwe_n),
    .oe_n       (oe_n),
    .dq_oe      (dq_oe)
);

// File: tb/burst_sram_tb_top.sv
`timescale 1ns/1ps
module burst_sram_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep_i = 1'b0;
    logic        ce_n = 1'b1;
    logic        cpu_strb_n = 1'b1;
    logic        ctl_strb_n = 1'b1;
    logic        adv_n = 1'b1;
    logic [7:0]  addr_i = '0;
    logic        bwe_n = 1'b1;
    logic [3:0]  lane_we_n = 4'hF;
    logic        oe_n = 1'b0;
    logic        burst_mode = 1'b0;
    logic [31:0] wdata = '0;
    logic [3:0]  wpar = '0;
    logic [31:0] rdata;
    logic [3:0]  rpar;
    logic        dq_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [35:0] ref_mem [256];

    always #2.5 clk = ~clk;

    burst_sram dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .ce_n(ce_n),
        .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .adv_n(adv_n),
        .addr_i(addr_i), .bwe_n(bwe_n), .lane_we_n(lane_we_n), .oe_n(oe_n),
        .burst_mode(burst_mode), .wdata(wdata), .wpar(wpar),
        .rdata(rdata), .rpar(rpar), .dq_oe(dq_oe)
    );

    function automatic logic [35:0] pat(input int a);
        logic [7:0] b;
        b = 8'(a);
        return {b[3:0], b ^ 8'h5A, b, 8'hC3, ~b};
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_nop();
        cpu_strb_n = 1'b1;
        ctl_strb_n = 1'b1;
        adv_n      = 1'b1;
        bwe_n      = 1'b1;
        lane_we_n  = 4'hF;
    endtask

    task automatic chk_word(input string req, input int a);
        checks++;
        if ({rpar, rdata} !== ref_mem[a]) begin
            errors++;
            $display("FAIL %s: word %0d got %h expected %h", req, a, {rpar, rdata}, ref_mem[a]);
        end
    endtask

    task automatic chk_oe(input string req, input logic exp);
        checks++;
        if (dq_oe !== exp) begin
            errors++;
            $display("FAIL %s: dq_oe got %b expected %b", req, dq_oe, exp);
        end
    endtask

    task automatic wr_ctl(input int a, input logic [31:0] d, input logic [3:0] p, input logic [3:0] lanes);
        ce_n = 1'b0; ctl_strb_n = 1'b0; bwe_n = 1'b0;
        addr_i = 8'(a); lane_we_n = lanes; wdata = d; wpar = p;
        tick();
        set_nop();
        for (int i = 0; i < 4; i++) begin
            if (!lanes[i]) begin
                ref_mem[a][8*i +: 8] = d[8*i +: 8];
                ref_mem[a][32+i]     = p[i];
            end
        end
    endtask

    task automatic rd_ctl(input int a);
        ce_n = 1'b0; ctl_strb_n = 1'b0; bwe_n = 1'b1; addr_i = 8'(a);
        tick();
        set_nop();
    endtask

    // R13
    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk_oe("R13 during reset", 1'b0);
        rst_n = 1'b1;
        tick();
        chk_oe("R13 after reset", 1'b0);
        checks++;
        if ({rpar, rdata} !== 36'h0) begin
            errors++;
            $display("FAIL R13: read reg got %h expected %h", {rpar, rdata}, 36'h0);
        end
    endtask

    // R8, R1, R7
    task automatic t_fill_and_read();
        for (int a = 0; a < 16; a++) begin
            wr_ctl(a, pat(a)[31:0], pat(a)[35:32], 4'h0);
            chk_oe("R8 write phase", 1'b0);
        end
        for (int a = 0; a < 16; a++) begin
            rd_ctl(a);
            chk_oe("R1 read drive", 1'b1);
            chk_word("R1 read data", a);
        end
        oe_n = 1'b1;
        rd_ctl(5);
        chk_oe("R7 oe_n high", 1'b0);
        chk_word("R7 data loaded", 5);
        oe_n = 1'b0;
        #1;
        chk_oe("R7 oe_n low again", 1'b1);
    endtask

    // R3
    task automatic t_linear();
        burst_mode = 1'b0;
        rd_ctl(5);
        chk_word("R3 start", 5);
        for (int k = 1; k <= 4; k++) begin
            adv_n = 1'b0;
            tick();
            chk_word("R3 linear step", 4 + ((1 + k) % 4));
        end
        adv_n = 1'b1;
    endtask

    // R4
    task automatic t_interleave();
        burst_mode = 1'b1;
        rd_ctl(11);
        chk_word("R4 start", 11);
        for (int k = 1; k <= 3; k++) begin
            adv_n = 1'b0;
            tick();
            chk_word("R4 interleaved step", 8 + (3 ^ k));
        end
        adv_n = 1'b1;
        rd_ctl(13);
        adv_n = 1'b0;
        tick();
        chk_word("R4 interleaved from 1", 12);
        adv_n = 1'b1;
        burst_mode = 1'b0;
    endtask

    // R12
    task automatic t_hold();
        rd_ctl(9);
        adv_n = 1'b0;
        tick();
        adv_n = 1'b1;
        chk_word("R12 advanced", 10);
        tick();
        chk_word("R12 hold repeats", 10);
        chk_oe("R12 hold drives", 1'b1);
    endtask

    // R6
    task automatic t_lanes();
        wr_ctl(2, 32'hDEAD_BEEF, 4'b0110, 4'b1010);
        rd_ctl(2);
        chk_oe("R6 read after write", 1'b1);
        chk_word("R6 lane merge", 2);
    endtask

    // R5
    task automatic t_bwe_off();
        ce_n = 1'b0; ctl_strb_n = 1'b0; bwe_n = 1'b1; lane_we_n = 4'h0;
        addr_i = 8'd4; wdata = 32'h0BAD_0BAD; wpar = 4'hF;
        tick();
        set_nop();
        chk_oe("R5 treated as read", 1'b1);
        chk_word("R5 read old data", 4);
        rd_ctl(4);
        chk_word("R5 memory unchanged", 4);
    endtask

    // R2
    task automatic t_priority();
        ce_n = 1'b0; cpu_strb_n = 1'b0; ctl_strb_n = 1'b0; bwe_n = 1'b0;
        lane_we_n = 4'h0; addr_i = 8'd3; wdata = 32'h1234_5678; wpar = 4'h9;
        tick();
        set_nop();
        chk_oe("R2 processor strobe reads", 1'b1);
        chk_word("R2 read data", 3);
        rd_ctl(3);
        chk_word("R2 memory unchanged", 3);
    endtask

    // R10, R9
    task automatic t_deselect();
        ce_n = 1'b1; ctl_strb_n = 1'b0; bwe_n = 1'b0; lane_we_n = 4'h0;
        addr_i = 8'd6; wdata = 32'hFFFF_0000; wpar = 4'h5;
        tick();
        set_nop();
        chk_oe("R10 deselected quiet", 1'b0);
        chk_word("R10 read reg held", 3);
        ce_n = 1'b0;
        tick();
        chk_oe("R9 first cycle quiet", 1'b0);
        chk_word("R10 address held", 3);
        tick();
        chk_oe("R9 drives after first", 1'b1);
        rd_ctl(6);
        chk_word("R10 no write while deselected", 6);
    endtask

    // R11, R9
    task automatic t_sleep();
        sleep_i = 1'b1;
        ce_n = 1'b0; ctl_strb_n = 1'b0; bwe_n = 1'b0; lane_we_n = 4'h0;
        addr_i = 8'd7; wdata = 32'h7777_7777; wpar = 4'hA;
        #1;
        chk_oe("R11 immediate quiet", 1'b0);
        @(posedge clk);
        @(negedge clk);
        chk_oe("R11 quiet across edge", 1'b0);
        chk_word("R11 no read in sleep", 6);
        sleep_i = 1'b0;
        set_nop();
        rd_ctl(7);
        chk_oe("R9 quiet after sleep", 1'b0);
        chk_word("R11 contents kept", 7);
        tick();
        chk_oe("R11 drives again", 1'b1);
        chk_word("R11 hold read", 7);
    endtask

    initial begin
        for (int a = 0; a < 256; a++) ref_mem[a] = 'x;
        t_reset();
        t_fill_and_read();
        t_linear();
        t_interleave();
        t_hold();
        t_lanes();
        t_bwe_off();
        t_priority();
        t_deselect();
        t_sleep();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule